// File: doc/BRIEF.md
# CAN Frame Error Detection Monitor

This block sits next to a CAN frame sequencer and watches the sampled bus bit stream together with the bit that the node itself drove. For every sampled bit, the sequencer supplies a set of position qualifiers. These say whether the bit lies in arbitration, the ACK slot, one of the fixed recessive fields (CRC delimiter, ACK delimiter, end of frame, interframe space) or the bit-stuffed region. The sequencer also says whether this node is the transmitter. From these inputs the monitor finds five kinds of frame error: bit, stuff, form, acknowledge and CRC mismatch. It also requests an error frame whenever any of them occurs. The CRC itself is computed elsewhere, and only its compare result arrives here.

Dominant is logic 0 and recessive is logic 1. After the first error in a frame, the monitor goes quiet. It reports nothing more until the sequencer pulses the frame-restart input, which also clears the same-polarity run count. All outputs are registered.

Top module: `canmon_top`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, every error output and err_frame_req are 0.
- R2: While is_tx is 1, a strobed bit (bit_valid=1) whose rx_bit differs from tx_bit pulses err_bit for one cycle in the cycle after the strobe, unless R3 applies.
- R3: A strobed bit with tx_bit=1 (recessive) and rx_bit=0 (dominant) raises no err_bit while in_arb or in_ack_slot is 1. A strobed bit with tx_bit=0 and rx_bit=1 in arbitration is still flagged.
- R4: While in_stuffed is 1, strobed bits build a same-polarity run that restarts at 1 on every polarity change. The sixth equal bit in a row pulses err_stuff in the following cycle. The run is cleared by any strobed bit with in_stuffed=0, and no stuff error is raised outside the region.
- R5: A strobed rx_bit of 0 while in_crc_delim, in_ack_delim, in_eof or in_ifs is 1 pulses err_form in the following cycle.
- R6: While is_tx is 1, a strobed rx_bit of 1 in the ACK slot (in_ack_slot=1) pulses err_ack in the following cycle.
- R7: A cycle with crc_valid=1 and crc_match=0 pulses err_crc in the following cycle, with no need for bit_valid.
- R8: err_frame_req pulses in exactly the cycles in which at least one error output pulses. Several classes may pulse together.
- R9: After any error, no error output or request pulses until frame_restart is seen. Checks arriving in the same cycle as frame_restart are not reported, and frame_restart also clears the run count.
- R10: While is_tx is 0, neither err_bit nor err_ack is raised, whatever tx_bit and rx_bit are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: one sampled bus bit this cycle |
| tx_bit | input | 1 | Level this node transmitted (0 dominant) |
| rx_bit | input | 1 | Level sampled on the bus |
| is_tx | input | 1 | Node is transmitter of the current frame |
| in_arb | input | 1 | Bit lies in the arbitration field |
| in_ack_slot | input | 1 | Bit is the ACK slot |
| in_crc_delim | input | 1 | Bit is the CRC delimiter |
| in_ack_delim | input | 1 | Bit is the ACK delimiter |
| in_eof | input | 1 | Bit lies in end of frame |
| in_ifs | input | 1 | Bit lies in the interframe space |
| in_stuffed | input | 1 | Bit lies between start of frame and CRC delimiter |
| crc_valid | input | 1 | CRC compare result is valid this cycle |
| crc_match | input | 1 | Received CRC equals computed CRC |
| frame_restart | input | 1 | Re-arm checks and clear run count |
| err_bit | output | 1 | Bit error pulse |
| err_stuff | output | 1 | Stuff error pulse |
| err_form | output | 1 | Form error pulse |
| err_ack | output | 1 | Acknowledge error pulse |
| err_crc | output | 1 | CRC error pulse |
| err_frame_req | output | 1 | Error frame request pulse |

## Verification
Random bit streams are applied with a strong bias toward repeated levels. This pushes runs past the stuffing limit both inside and outside the stuffed region, and separates a correct run counter from one that never resets on a polarity change or that counts outside the region. The qualifiers are drawn at random, so mismatches land in arbitration, the ACK slot and plain data. This tells the one-way arbitration mask apart from a mask applied in both directions or not applied at all. Directed sequences cover the following:
- a run of exactly five equal bits against a run of six;
- dominant levels in each fixed recessive field;
- a missing acknowledge, both as transmitter and as receiver;
- a second error arriving before restart, and a violation arriving in the same cycle as restart.

// File: rtl/canmon_pkg.sv
package canmon_pkg;
  localparam logic DOMINANT  = 1'b0;
  localparam logic RECESSIVE = 1'b1;

  typedef struct packed {
    logic bit_e;
    logic stuff_e;
    logic form_e;
    logic ack_e;
    logic crc_e;
  } err_vec_t;
endpackage

// File: rtl/canmon_stuff_chk.sv
module canmon_stuff_chk #(
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bit_valid,
  input  logic rx_bit,
  input  logic in_stuffed,
  output logic stuff_viol
);
  localparam int unsigned CNT_W   = $clog2(RUN_LIMIT + 2);
  localparam logic [CNT_W-1:0] VIOL_CNT = CNT_W'(RUN_LIMIT + 1);

  logic [CNT_W-1:0] run_q, run_d;
  logic             prev_q;

  // Next run length: restart at 1 on a new region or a polarity change.
  always_comb begin
    run_d = run_q;
    if (bit_valid) begin
      if (!in_stuffed)
        run_d = '0;
      else if (run_q == '0 || rx_bit != prev_q)
        run_d = CNT_W'(1);
      else if (run_q < VIOL_CNT)
        run_d = run_q + CNT_W'(1);
    end
  end

  assign stuff_viol = bit_valid && in_stuffed && (run_d == VIOL_CNT);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      run_q  <= '0;
      prev_q <= 1'b1;
    end else if (bit_valid) begin
      run_q  <= run_d;
      prev_q <= rx_bit;
    end
  end
endmodule

// File: rtl/canmon_field_chk.sv
module canmon_field_chk
  import canmon_pkg::*;
(
  input  logic     bit_valid,
  input  logic     tx_bit,
  input  logic     rx_bit,
  input  logic     is_tx,
  input  logic     in_arb,
  input  logic     in_ack_slot,
  input  logic     in_crc_delim,
  input  logic     in_ack_delim,
  input  logic     in_eof,
  input  logic     in_ifs,
  input  logic     crc_valid,
  input  logic     crc_match,
  output logic     bit_viol,
  output logic     form_viol,
  output logic     ack_viol,
  output logic     crc_viol
);
  logic lost_arb_ok;
  logic fixed_field;

  // Recessive sent, dominant seen: legal where others may drive dominant.
  assign lost_arb_ok = (tx_bit == RECESSIVE) && (rx_bit == DOMINANT) &&
                       (in_arb || in_ack_slot);
  assign fixed_field = in_crc_delim || in_ack_delim || in_eof || in_ifs;

  always_comb begin
    bit_viol  = bit_valid && is_tx && (tx_bit != rx_bit) && !lost_arb_ok;
    form_viol = bit_valid && fixed_field && (rx_bit == DOMINANT);
    ack_viol  = bit_valid && is_tx && in_ack_slot && (rx_bit == RECESSIVE);
    crc_viol  = crc_valid && !crc_match;
  end
endmodule

// File: rtl/canmon_err_gate.sv
module canmon_err_gate
  import canmon_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     restart,
  input  err_vec_t raw,
  output err_vec_t err_q,
  output logic     req_q
);
  logic halted_q;
  logic any_raw;

  assign any_raw = |raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      err_q    <= '0;
      req_q    <= 1'b0;
    end else if (restart) begin
      halted_q <= 1'b0;
      err_q    <= '0;
      req_q    <= 1'b0;
    end else if (halted_q) begin
      err_q    <= '0;
      req_q    <= 1'b0;
    end else begin
      err_q    <= raw;
      req_q    <= any_raw;
      halted_q <= any_raw;
    end
  end
endmodule

// File: rtl/canmon_top.sv
module canmon_top
  import canmon_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic tx_bit,
  input  logic rx_bit,
  input  logic is_tx,
  input  logic in_arb,
  input  logic in_ack_slot,
  input  logic in_crc_delim,
  input  logic in_ack_delim,
  input  logic in_eof,
  input  logic in_ifs,
  input  logic in_stuffed,
  input  logic crc_valid,
  input  logic crc_match,
  input  logic frame_restart,
  output logic err_bit,
  output logic err_stuff,
  output logic err_form,
  output logic err_ack,
  output logic err_crc,
  output logic err_frame_req
);
  err_vec_t raw, err_q;

  canmon_stuff_chk #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
    .clk        (clk),
    .rst        (rst),
    .restart    (frame_restart),
    .bit_valid  (bit_valid),
    .rx_bit     (rx_bit),
    .in_stuffed (in_stuffed),
    .stuff_viol (raw.stuff_e)
  );

  canmon_field_chk u_field (
    .bit_valid    (bit_valid),
    .tx_bit       (tx_bit),
    .rx_bit       (rx_bit),
    .is_tx        (is_tx),
    .in_arb       (in_arb),
    .in_ack_slot  (in_ack_slot),
    .in_crc_delim (in_crc_delim),
    .in_ack_delim (in_ack_delim),
    .in_eof       (in_eof),
    .in_ifs       (in_ifs),
    .crc_valid    (crc_valid),
    .crc_match    (crc_match),
    .bit_viol     (raw.bit_e),
    .form_viol    (raw.form_e),
    .ack_viol     (raw.ack_e),
    .crc_viol     (raw.crc_e)
  );

  canmon_err_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_restart),
    .raw     (raw),
    .err_q   (err_q),
    .req_q   (err_frame_req)
  );

  assign err_bit   = err_q.bit_e;
  assign err_stuff = err_q.stuff_e;
  assign err_form  = err_q.form_e;
  assign err_ack   = err_q.ack_e;
  assign err_crc   = err_q.crc_e;
endmodule

// File: rtl/canmon_checker.sv
module canmon_checker (
  input logic clk,
  input logic rst,
  input logic bit_valid,
  input logic tx_bit,
  input logic rx_bit,
  input logic is_tx,
  input logic in_arb,
  input logic in_ack_slot,
  input logic in_crc_delim,
  input logic in_ack_delim,
  input logic in_eof,
  input logic in_ifs,
  input logic in_stuffed,
  input logic crc_valid,
  input logic crc_match,
  input logic frame_restart,
  input logic err_bit,
  input logic err_stuff,
  input logic err_form,
  input logic err_ack,
  input logic err_crc,
  input logic err_frame_req
);
  AST_BIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_bit |-> $past(bit_valid && is_tx && (tx_bit != rx_bit))); // R2
  AST_BIT_MASK: assert property (@(posedge clk) disable iff (rst)
    err_bit |-> !$past(tx_bit && !rx_bit && (in_arb || in_ack_slot))); // R3
  AST_STUFF_REGION: assert property (@(posedge clk) disable iff (rst)
    err_stuff |-> $past(bit_valid && in_stuffed)); // R4
  AST_FORM_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_form |-> $past(bit_valid && !rx_bit &&
                       (in_crc_delim || in_ack_delim || in_eof || in_ifs))); // R5
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_ack |-> $past(bit_valid && is_tx && in_ack_slot && rx_bit)); // R6
  AST_CRC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_crc |-> $past(crc_valid && !crc_match)); // R7
  AST_REQ_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    (err_bit || err_stuff || err_form || err_ack || err_crc) |-> err_frame_req); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_frame_req |=> !err_frame_req); // R9
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(frame_restart) |-> !err_frame_req); // R9
  AST_RX_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(is_tx) |-> !(err_bit || err_ack)); // R10
endmodule

bind canmon_top canmon_checker u_chk (.*);

// File: tb/canmon_top_test.sv
module canmon_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 0, tx_bit = 1, rx_bit = 1, is_tx = 0;
  logic in_arb = 0, in_ack_slot = 0, in_crc_delim = 0, in_ack_delim = 0;
  logic in_eof = 0, in_ifs = 0, in_stuffed = 0;
  logic crc_valid = 0, crc_match = 1, frame_restart = 0;
  logic err_bit, err_stuff, err_form, err_ack, err_crc, err_frame_req;

  int vectors = 0;
  int fails = 0;

  // bench reference state
  bit       m_halt = 0;
  int       m_run = 0;
  bit       m_prev = 1;
  bit [5:0] exp_v = '0;   // {bit,stuff,form,ack,crc,req}
  string    ctx = "R1";

  always #10 clk = ~clk;

  canmon_top uut (.*);

  task automatic chk1(input string tag, input logic act, input bit expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s [%s] actual=%0b expected=%0b at %0t", tag, ctx, act, expv, $time);
    end
  endtask

  task automatic compare_all();
    chk1("R2/R3 err_bit", err_bit, exp_v[5]);
    chk1("R4 err_stuff", err_stuff, exp_v[4]);
    chk1("R5 err_form", err_form, exp_v[3]);
    chk1("R6 err_ack", err_ack, exp_v[2]);
    chk1("R7 err_crc", err_crc, exp_v[1]);
    chk1("R8 err_frame_req", err_frame_req, exp_v[0]);
  endtask

  // Reference model of one cycle, from the requirements.
  function automatic bit [5:0] predict();
    bit eb, es, ef, ea, ec;
    int nrun;
    eb = 0; es = 0; ef = 0; ea = 0; ec = 0;
    if (frame_restart) begin
      m_halt = 0; m_run = 0; m_prev = 1;
      return '0;
    end
    if (bit_valid) begin
      if (!in_stuffed) nrun = 0;
      else if (m_run == 0 || rx_bit != m_prev) nrun = 1;
      else nrun = (m_run < 6) ? m_run + 1 : 6;
      es = in_stuffed && nrun == 6;
      m_run = nrun;
      m_prev = rx_bit;
      eb = is_tx && (tx_bit != rx_bit) &&
           !(tx_bit && !rx_bit && (in_arb || in_ack_slot));
      ef = !rx_bit && (in_crc_delim || in_ack_delim || in_eof || in_ifs);
      ea = is_tx && in_ack_slot && rx_bit;
    end
    ec = crc_valid && !crc_match;
    if (m_halt) return '0;
    if (eb | es | ef | ea | ec) m_halt = 1;
    return {eb, es, ef, ea, ec, (eb | es | ef | ea | ec)};
  endfunction

  task automatic clear_q();
    bit_valid = 0; is_tx = 0; in_arb = 0; in_ack_slot = 0; in_crc_delim = 0;
    in_ack_delim = 0; in_eof = 0; in_ifs = 0; in_stuffed = 0;
    crc_valid = 0; crc_match = 1; frame_restart = 0; tx_bit = 1; rx_bit = 1;
  endtask

  // Inputs already set: apply for one edge, then compare at the next negedge.
  task automatic step();
    exp_v = predict();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic restart();
    clear_q(); frame_restart = 1; step(); frame_restart = 0;
  endtask

  task automatic stuffed_bit(input logic b);
    clear_q(); bit_valid = 1; in_stuffed = 1; rx_bit = b; tx_bit = b; step();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 reset
    @(negedge clk);
    exp_v = '0; compare_all();
    @(negedge clk);
    rst = 0;
    ctx = "R1"; clear_q(); step();

    // R4: five equal bits pass, sixth flags
    ctx = "R4 five"; restart();
    for (int i = 0; i < 5; i++) stuffed_bit(0);
    stuffed_bit(1);
    ctx = "R4 six";
    for (int i = 0; i < 5; i++) stuffed_bit(1);
    // R9 halted: next violation ignored
    ctx = "R9 halted";
    clear_q(); bit_valid = 1; in_eof = 1; rx_bit = 0; step();
    // R4 outside region no error
    ctx = "R4 outside"; restart();
    for (int i = 0; i < 8; i++) begin clear_q(); bit_valid = 1; rx_bit = 0; step(); end

    // R3 masking in arbitration; reverse direction flagged
    ctx = "R3 mask"; restart();
    clear_q(); bit_valid = 1; is_tx = 1; in_arb = 1; tx_bit = 1; rx_bit = 0; step();
    clear_q(); bit_valid = 1; is_tx = 1; in_ack_slot = 1; tx_bit = 1; rx_bit = 0; step();
    ctx = "R3 reverse";
    clear_q(); bit_valid = 1; is_tx = 1; in_arb = 1; tx_bit = 0; rx_bit = 1; step();

    // R6 ack missing as transmitter; R10 as receiver
    ctx = "R6 tx"; restart();
    clear_q(); bit_valid = 1; is_tx = 1; in_ack_slot = 1; tx_bit = 1; rx_bit = 1; step();
    ctx = "R10 rx"; restart();
    clear_q(); bit_valid = 1; in_ack_slot = 1; tx_bit = 0; rx_bit = 1; step();

    // R5 each fixed field
    for (int f = 0; f < 4; f++) begin
      ctx = "R5 field"; restart();
      clear_q(); bit_valid = 1; rx_bit = 0;
      in_crc_delim = (f == 0); in_ack_delim = (f == 1); in_eof = (f == 2); in_ifs = (f == 3);
      step();
    end

    // R7 crc mismatch without strobe
    ctx = "R7"; restart();
    clear_q(); crc_valid = 1; crc_match = 0; step();
    // R9 violation in restart cycle is dropped
    ctx = "R9 same cycle";
    clear_q(); frame_restart = 1; bit_valid = 1; in_eof = 1; rx_bit = 0; step();

    // Random mix
    ctx = "random"; restart();
    for (int n = 0; n < 4000; n++) begin
      logic keep;
      keep = ($urandom % 100) < 80;
      clear_q();
      frame_restart = ($urandom % 100) < 8;
      bit_valid = ($urandom % 100) < 75;
      rx_bit = keep ? m_prev : logic'($urandom % 2);
      tx_bit = (($urandom % 100) < 90) ? rx_bit : logic'($urandom % 2);
      is_tx = $urandom % 2;
      in_stuffed = ($urandom % 100) < 85;
      if (!in_stuffed) begin
        case ($urandom % 6)
          0: in_crc_delim = 1;
          1: in_ack_delim = 1;
          2: in_eof = 1;
          3: in_ifs = 1;
          4: in_ack_slot = 1;
          default: ;
        endcase
        if (($urandom % 100) < 80 && !in_ack_slot) rx_bit = 1;
      end else begin
        in_arb = ($urandom % 100) < 30;
      end
      crc_valid = ($urandom % 100) < 2;
      crc_match = $urandom % 2;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule